// File: doc/BRIEF.md
# Snoop Tag Shadow for a Non-Coherent Cache

This block lets a processor whose data cache has no coherence hardware share memory with a second, coherent bus master. It sits on the shared bus as a pure observer and builds a content-addressable shadow of the line tags that the non-coherent processor has pulled into its cache. A line is eight words of four bytes, moved as one burst, so a tag is the address with its five low bits dropped. The shadow is filled only from transactions that the non-coherent processor starts. Only transactions started by the other master are compared against the shadow.

When the other master touches a shadowed line, with either a read or a write, the block pulls an active-low interrupt line low. It also captures the full address and the direction of that access, so that the interrupt handler can write back a dirty line or discard a clean one. The handler then pulses the clear input. That pulse releases the interrupt and drops the captured line from the shadow. Further hits are held off while an interrupt is outstanding.

Addresses in a configurable lock window are never shadowed, because lock variables must stay uncached. When the shadow is full, a new line displaces the entry that was allocated earliest.

Top module: `snp_tagcam`

## Requirements
- R1: A valid transaction with `mon_src`=0 (local) allocates its line tag, `mon_addr[AW-1:5]`, unless that tag is already held; an access to a line that is already held changes neither the contents nor the replacement order.
- R2: A valid transaction with `mon_src`=1 (remote), read or write, whose tag matches a valid entry drives `irq_n` low at the next rising clock edge. A remote miss never drives `irq_n` low, and neither does any local transaction.
- R3: Once low, `irq_n` stays low until a cycle with `sw_clear`=1, and goes high at the clock edge that samples that pulse.
- R4: At the edge where `irq_n` falls, `held_addr` takes the full address of the hitting transaction and `held_wr` takes its direction (1 = write). Both keep their values until the next accepted hit.
- R5: While `irq_n` is low, further remote hits are ignored: `irq_n`, `held_addr` and `held_wr` do not change.
- R6: A clear that releases the interrupt also invalidates the entry holding the line of `held_addr`, so a later remote access to that line misses. A `sw_clear` pulse while `irq_n` is high has no effect.
- R7: A local transaction whose address lies in `[LOCK_BASE, LOCK_BASE+LOCK_BYTES)` is never allocated.
- R8: An allocation takes a free entry when one exists. When all `ENTRIES` are valid, it replaces the valid entry allocated earliest. Entries that have been invalidated drop out of that order.
- R9: After reset `irq_n` is high, `held_addr` and `held_wr` are zero, and no entry is valid.
- R10: No line tag is ever held in more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_valid | input | 1 | A bus transaction is observed this cycle |
| mon_src | input | 1 | Initiator: 0 = non-coherent processor, 1 = other master |
| mon_write | input | 1 | Direction of the observed transaction, 1 = write |
| mon_addr | input | AW | Byte address of the observed transaction |
| sw_clear | input | 1 | One-cycle pulse from the handler: release the interrupt and drop the captured line |
| irq_n | output | 1 | Active-low fast interrupt to the non-coherent processor |
| held_addr | output | AW | Address captured at the last accepted hit |
| held_wr | output | 1 | Direction captured at the last accepted hit |

## Verification
The in-RTL assertions check the following on every cycle:
- the interrupt falls only after a remote transaction and rises only after a clear (R2, R3);
- the captured address holds steady while the interrupt is pending (R4, R5);
- at most one entry matches any address (R10);
- no valid entry lies in the lock window (R7);
- the number of valid entries drops only on a clear (R6).

Other properties need a reference model and only the bench's sequences can show them:
- which line a full shadow gives up (R8);
- that a repeated local access leaves the eviction order alone (R1);
- that a cleared line really misses afterwards (R6).

The bench runs a long pseudo-random mix of local fills, remote probes over every word offset, and clears across more lines than the shadow holds, and compares the results against a FIFO model.

// File: rtl/snp_pkg.sv
package snp_pkg;
    // Initiator of an observed bus transaction.
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_REMOTE = 1'b1
    } src_e;
endpackage

// File: rtl/snp_tag_match.sv
// Parallel tag comparison over all entries, with an index encoder.
module snp_tag_match #(
    parameter int N  = 4,
    parameter int TW = 27,
    parameter int IW = 2
) (
    input  logic [N-1:0][TW-1:0] tags,
    input  logic [N-1:0]         vld,
    input  logic [TW-1:0]        key,
    output logic [N-1:0]         hit,
    output logic                 any,
    output logic [IW-1:0]        idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        any = |hit;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/snp_slot_pick.sv
// Picks the lowest free entry and the oldest valid entry.
// The oldest valid entry is the one whose age rank equals N-1.
module snp_slot_pick #(
    parameter int N    = 4,
    parameter int AGEW = 2,
    parameter int IW   = 2
) (
    input  logic [N-1:0]           vld,
    input  logic [N-1:0][AGEW-1:0] age,
    output logic                   free_any,
    output logic [IW-1:0]          free_idx,
    output logic [IW-1:0]          old_idx
);
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
            if (vld[i] && (age[i] == AGEW'(N - 1))) old_idx = IW'(i);
        end
    end
endmodule

// File: rtl/snp_tagcam.sv
module snp_tagcam
    import snp_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            ENTRIES    = 4,
    parameter int            WORD_BYTES = 4,
    parameter int            LINE_WORDS = 8,
    parameter logic [AW-1:0] LOCK_BASE  = 32'hFFFF_F000,
    parameter int            LOCK_BYTES = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mon_valid,
    input  logic          mon_src,
    input  logic          mon_write,
    input  logic [AW-1:0] mon_addr,
    input  logic          sw_clear,
    output logic          irq_n,
    output logic [AW-1:0] held_addr,
    output logic          held_wr
);
    localparam int OFF  = $clog2(WORD_BYTES * LINE_WORDS);
    localparam int TW   = AW - OFF;
    localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int AGEW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [AW-1:0] LOCK_END = LOCK_BASE + AW'(LOCK_BYTES);

    typedef struct packed {
        logic [ENTRIES-1:0][TW-1:0]   tag;
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0][AGEW-1:0] age;   // 0 = newest
        logic                         pend;
        logic [AW-1:0]                held;
        logic                         hwr;
    } st_t;

    st_t q, n;

    function automatic logic in_lock(input logic [TW-1:0] t);
        return (t >= LOCK_BASE[AW-1:OFF]) && (t < LOCK_END[AW-1:OFF]);
    endfunction

    logic [TW-1:0]      mon_tag;
    logic [ENTRIES-1:0] mon_hit, clr_hit;
    logic               mon_any, clr_any;
    logic [IW-1:0]      mon_idx, clr_idx;
    logic               free_any;
    logic [IW-1:0]      free_idx, old_idx;

    assign mon_tag = mon_addr[AW-1:OFF];

    snp_tag_match #(.N(ENTRIES), .TW(TW), .IW(IW)) u_mon_match (
        .tags(q.tag), .vld(q.vld), .key(mon_tag),
        .hit(mon_hit), .any(mon_any), .idx(mon_idx)
    );

    snp_tag_match #(.N(ENTRIES), .TW(TW), .IW(IW)) u_clr_match (
        .tags(q.tag), .vld(q.vld), .key(q.held[AW-1:OFF]),
        .hit(clr_hit), .any(clr_any), .idx(clr_idx)
    );

    snp_slot_pick #(.N(ENTRIES), .AGEW(AGEW), .IW(IW)) u_pick (
        .vld(q.vld), .age(q.age),
        .free_any(free_any), .free_idx(free_idx), .old_idx(old_idx)
    );

    logic          clr_do, clr_inv, mon_local, mon_remote, present;
    logic [IW-1:0] slot;

    always_comb begin
        n          = q;
        clr_do     = sw_clear && q.pend;
        clr_inv    = clr_do && clr_any;
        mon_local  = mon_valid && (mon_src == SRC_LOCAL);
        mon_remote = mon_valid && (mon_src == SRC_REMOTE);
        present    = mon_any && !(clr_inv && (mon_idx == clr_idx));
        slot       = '0;

        // Handler clear: drop the captured line and close the gap in the age order.
        if (clr_inv) begin
            n.vld[clr_idx] = 1'b0;
            for (int j = 0; j < ENTRIES; j++) begin
                if (q.vld[j] && (q.age[j] > q.age[clr_idx])) n.age[j] = q.age[j] - 1'b1;
            end
        end
        if (clr_do) n.pend = 1'b0;

        // Fill from the non-coherent processor's own traffic.
        if (mon_local && !in_lock(mon_tag) && !present) begin
            slot = free_any ? free_idx : (clr_inv ? clr_idx : old_idx);
            for (int j = 0; j < ENTRIES; j++) begin
                if (n.vld[j] && (IW'(j) != slot)) n.age[j] = n.age[j] + 1'b1;
            end
            n.vld[slot] = 1'b1;
            n.tag[slot] = mon_tag;
            n.age[slot] = '0;
        end

        // Snoop from the other master.
        if (mon_remote && mon_any && !q.pend) begin
            n.pend = 1'b1;
            n.held = mon_addr;
            n.hwr  = mon_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign irq_n     = !q.pend;
    assign held_addr = q.held;
    assign held_wr   = q.hwr;

    // R2
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(mon_valid && (mon_src == SRC_REMOTE)));

    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(sw_clear));

    // R5
    held_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && $past(!irq_n)) |-> ($stable(held_addr) && $stable(held_wr)));

    // R10
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mon_hit));

    // R6
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(q.vld) < $past($countones(q.vld))) |-> $past(sw_clear));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_lock_chk
        // R7
        lock_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q.vld[g] |-> !in_lock(q.tag[g]));
    end
endmodule

// File: tb/tb_snp_tagcam.sv
module tb_snp_tagcam;
    localparam int AW = 16;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_valid = 1'b0, mon_src = 1'b0, mon_write = 1'b0, sw_clear = 1'b0;
    logic [AW-1:0] mon_addr = '0;
    logic          irq_n, held_wr;
    logic [AW-1:0] held_addr;

    always #10 clk = ~clk;

    snp_tagcam #(.AW(AW), .ENTRIES(NE), .WORD_BYTES(4), .LINE_WORDS(8),
                 .LOCK_BASE(16'hF000), .LOCK_BYTES(256)) dut (
        .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_src(mon_src),
        .mon_write(mon_write), .mon_addr(mon_addr), .sw_clear(sw_clear),
        .irq_n(irq_n), .held_addr(held_addr), .held_wr(held_wr)
    );

    int nchk = 0, nerr = 0;
    bit finished = 1'b0;

    // Reference model: mt[0] is the oldest allocation.
    int            mt[NE];
    int            mcnt = 0;
    bit            mpend = 1'b0;
    logic [AW-1:0] mheld = '0;
    logic          mhwr = 1'b0;

    function automatic int mfind(input int t);
        for (int i = 0; i < mcnt; i++) if (mt[i] == t) return i;
        return -1;
    endfunction

    function automatic void mremove(input int k);
        for (int i = k; i < NE - 1; i++) mt[i] = mt[i+1];
        mcnt--;
    endfunction

    function automatic bit is_lock(input logic [AW-1:0] a);
        return (a >= 16'hF000) && (a < 16'hF100);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        chk(irq_n == !mpend, req, "irq_n", int'(irq_n), int'(!mpend));
        chk(held_addr == mheld, req, "held_addr", int'(held_addr), int'(mheld));
        chk(held_wr == mhwr, req, "held_wr", int'(held_wr), int'(mhwr));
    endtask

    // kind: 0 = local access, 1 = remote access, 2 = handler clear
    task automatic op(input int kind, input logic [AW-1:0] a, input logic wr, input string req);
        int t;
        @(negedge clk);
        if (kind == 2) sw_clear = 1'b1;
        else begin
            mon_valid = 1'b1; mon_src = (kind == 1); mon_write = wr; mon_addr = a;
        end
        @(negedge clk);
        mon_valid = 1'b0; sw_clear = 1'b0; mon_src = 1'b0; mon_write = 1'b0;
        t = int'(a >> 5);
        if (kind == 0) begin
            if (!is_lock(a) && mfind(t) < 0) begin
                if (mcnt == NE) mremove(0);
                mt[mcnt] = t; mcnt++;
            end
        end else if (kind == 1) begin
            if (!mpend && mfind(t) >= 0) begin mpend = 1'b1; mheld = a; mhwr = wr; end
        end else if (mpend) begin
            int k;
            k = mfind(int'(mheld >> 5));
            if (k >= 0) mremove(k);
            mpend = 1'b0;
        end
        check_outs(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_outs("R9");
        rst_n = 1'b1;
        op(1, 16'h0040, 0, "R2");            // remote miss on empty shadow
        op(0, 16'h0040, 0, "R1");
        op(1, 16'h0044, 0, "R2");            // hit on a held line
        op(1, 16'h0040, 1, "R5");            // blocked while pending
        op(0, 16'h0044, 0, "R2");            // local traffic never interrupts
        op(2, 16'h0000, 0, "R3");
        op(1, 16'h0048, 0, "R6");            // cleared line now misses
        op(0, 16'h0040, 0, "R1");
        op(2, 16'h0000, 0, "R6");            // clear with nothing pending
        op(1, 16'h005C, 1, "R4");            // write hit, last word of the line
        op(2, 16'h0000, 0, "R3");
        op(0, 16'hF000, 0, "R7");
        op(1, 16'hF004, 1, "R7");
        // word-offset sweep on one line
        for (int w = 0; w < 8; w++) begin
            op(0, 16'h0300, 0, "R1");
            op(1, AW'(16'h0300 + w * 4), w[0], "R4");
            op(2, 16'h0000, 0, "R3");
        end
        // FIFO eviction
        for (int k = 0; k < 5; k++) op(0, AW'(16'h0100 + k * 32), 0, "R8");
        op(1, 16'h0100, 0, "R8");            // oldest displaced
        op(1, 16'h0120, 0, "R8");
        op(2, 16'h0000, 0, "R6");
        op(0, 16'h0140, 0, "R1");            // re-access keeps order
        op(0, 16'h01A0, 0, "R8");            // fills freed slot
        op(0, 16'h01C0, 0, "R8");            // evicts 0x140
        op(1, 16'h0140, 0, "R8");
        op(1, 16'h0160, 1, "R8");
        op(2, 16'h0000, 0, "R6");
        // pseudo-random mix over seven lines plus the lock window
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int s = 0; s < 500; s++) begin
                logic [AW-1:0] a;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                a = (lf[2:0] == 3'd7) ? AW'(16'hF000 + lf[6:4] * 4)
                                      : AW'(16'h0200 + lf[2:0] * 32 + lf[6:4] * 4);
                case (lf[10:8])
                    3'd0, 3'd1, 3'd2: op(0, a, lf[7], "R8");
                    3'd3, 3'd4, 3'd5: op(1, a, lf[7], "R2");
                    default:          op(2, a, 1'b0, "R6");
                endcase
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule